// File: doc/BRIEF.md
# FPGA Slave-SPI Configuration Sequencer

This block is a hardware master that loads the configuration memory of an SRAM-based FPGA through that device's slave SPI port. A host pulses `start`, then streams the bitstream one byte at a time over a valid/ready handshake and flags the final byte. The sequencer handles everything around the raw bytes:

- it pulses the active-low configuration reset while the chip select is held;
- it confirms that the target's done line has dropped;
- it holds the select through the housekeeping interval, then frees it briefly;
- it shifts the image out in SPI mode 0;
- it confirms that done has risen, then clocks out the trailing zero bytes that wake the loaded design.

A one-cycle finish pulse carries a 2-bit result code. A separate `operating` flag follows the synchronized done line at all times.

All timing comes from clock-cycle parameters. The serial clock is the system clock divided by `2*SCLK_HALF`. Elaboration stops if that rate falls outside 1 MHz to 25 MHz, or if the reset hold is shorter than the done-line synchronizer needs.

Top module: `fpga_cfg_seq`

## Requirements
- R1: A `start` pulse while idle raises `busy` in the next cycle. It also drives `cfg_rst_n` and `spi_cs_n` low together, and `cfg_rst_n` stays low for exactly RESET_CYC cycles. `cfg_rst_n` is never low while `spi_cs_n` is high.
- R2: `cfg_rst_n` returns high while `spi_cs_n` stays low. In a sequence without a reset failure, `spi_cs_n` then stays low for HK_CYC+1 cycles: one check cycle plus the housekeeping wait.
- R3: If the synchronized done line reads high in the check cycle after reset release, the sequence stops at once. `spi_cs_n` goes high, no SCLK edge is produced, and the finish status is 1 (reset failure).
- R4: Between the housekeeping wait and the first bitstream bit, `spi_cs_n` goes high for at least one cycle. A full sequence therefore shows exactly two falling and two rising edges of `spi_cs_n`.
- R5: Bytes are shifted MSB first in SPI mode 0. SCLK idles low, each SCLK level lasts SCLK_HALF system clocks, and MOSI changes only while SCLK is low. Every bitstream byte appears on the serial lines unchanged and in order.
- R6: `in_ready` is high only in the load phase while no byte is being shifted and the last byte has not yet been taken. A byte is taken only in a cycle with both `in_valid` and `in_ready` high, and `in_ready` stays low for the whole time that byte is being shifted.
- R7: If the synchronized done line reads low after the last byte, the finish status is 2 (load failure). No padding clocks are sent and `spi_cs_n` goes high.
- R8: If done reads high after the last byte, PAD_BYTES (default 7) zero bytes follow with MOSI at 0, which is 56 extra SCLK rising edges. The finish status is then 0 (success).
- R9: `fin_pulse` lasts exactly one cycle, `busy` is low in that cycle, and `fin_status` holds 0, 1 or 2, never 3.
- R10: `operating` equals the done input delayed by the two-flop synchronizer plus one register, so it follows a change of done within four cycles.
- R11: `start` has no effect while `busy` is high. The reset-low length and the select edge counts of the running sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration sequence (idle only) |
| in_data | input | 8 | Bitstream byte |
| in_valid | input | 1 | Byte on in_data is valid |
| in_last | input | 1 | Current byte is the final bitstream byte |
| in_ready | output | 1 | Sequencer can take a byte |
| cfg_rst_n | output | 1 | Active-low configuration reset to the target |
| spi_cs_n | output | 1 | Active-low chip select to the target |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the target |
| done_in | input | 1 | Target's done line (asynchronous) |
| busy | output | 1 | Sequence in progress |
| fin_pulse | output | 1 | One-cycle end-of-sequence strobe |
| fin_status | output | 2 | 0 success, 1 reset failure, 2 load failure |
| operating | output | 1 | Target reports its design as running |

## Verification
The bench builds the block with SCLK_HALF=2 at a 40 MHz nominal clock (10 MHz SCLK), RESET_CYC=5 and HK_CYC=30. These values shrink the housekeeping wait from tens of thousands of cycles to a few dozen. That lets successes, both failure kinds, single-byte images and a mid-sequence `start` all fit in one short run. The divider of 2 still keeps each SCLK level longer than one cycle, so a MOSI change while SCLK is high can be seen.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RHOLD, S_RCHK, S_HKEEP, S_GAP, S_LOAD, S_DCHK, S_PAD
  } seq_st_t;

  localparam logic [1:0] STAT_OK       = 2'd0;
  localparam logic [1:0] STAT_RST_FAIL = 2'd1;
  localparam logic [1:0] STAT_LD_FAIL  = 2'd2;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int HALF = 2,
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [BITS-1:0] din,
  output logic            active,
  output logic            fin,
  output logic            sclk,
  output logic            mosi
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(BITS);

  logic [DW-1:0]   div;
  logic [BW-1:0]   bitc;
  logic [BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      div <= '0; bitc <= '0; sh <= '0;
      active <= 1'b0; fin <= 1'b0; sclk <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          sh     <= din;
          active <= 1'b1;
          div    <= '0;
          bitc   <= '0;
          sclk   <= 1'b0;
        end
      end else if (div == DW'(HALF-1)) begin
        div  <= '0;
        sclk <= !sclk;
        if (sclk) begin
          if (bitc == BW'(BITS-1)) begin
            active <= 1'b0;
            fin    <= 1'b1;
            sh     <= '0;
          end else begin
            bitc <= bitc + 1'b1;
            sh   <= {sh[BITS-2:0], 1'b0};
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  assign mosi = sh[BITS-1];
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int SCLK_HALF  = 2,
  parameter int RESET_CYC  = 100,
  parameter int HK_CYC     = 120_000,
  parameter int PAD_BYTES  = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       cfg_rst_n,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       done_in,
  output logic       busy,
  output logic       fin_pulse,
  output logic [1:0] fin_status,
  output logic       operating
);
  localparam int SCLK_HZ = CLK_HZ / (2 * SCLK_HALF);
  localparam int TMAX    = (RESET_CYC > HK_CYC) ? RESET_CYC : HK_CYC;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int PW      = (PAD_BYTES > 1) ? $clog2(PAD_BYTES) : 1;

  generate
    if (SCLK_HZ > 25_000_000 || SCLK_HZ < 1_000_000) begin : g_bad_rate
      $error("fpga_cfg_seq: serial clock outside 1..25 MHz");
    end
    if (RESET_CYC < 3 || HK_CYC < 1 || PAD_BYTES < 1) begin : g_bad_timing
      $error("fpga_cfg_seq: timing parameters too small");
    end
  endgenerate

  seq_st_t        state, nxt;
  logic           done_s;
  logic           t_load, t_zero;
  logic [TW-1:0]  t_val;
  logic           ser_go, ser_active, ser_fin;
  logic [7:0]     ser_din;
  logic           last_q;
  logic [PW-1:0]  pad_cnt;
  logic [1:0]     stat_n, stat_q;
  logic           rstn_q, csn_q, busy_q, fin_q, oper_q;

  cfg_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(done_in), .q(done_s)
  );

  cfg_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .val(t_val), .zero(t_zero)
  );

  cfg_shifter #(.HALF(SCLK_HALF), .BITS(8)) u_ser (
    .clk(clk), .rst(rst), .go(ser_go), .din(ser_din),
    .active(ser_active), .fin(ser_fin), .sclk(spi_sclk), .mosi(spi_mosi)
  );

  assign in_ready = (state == S_LOAD) && !ser_active && !last_q;

  always_comb begin
    nxt     = state;
    t_load  = 1'b0;
    t_val   = '0;
    ser_go  = 1'b0;
    ser_din = in_data;
    stat_n  = stat_q;
    unique case (state)
      S_IDLE: if (start) begin
        nxt    = S_RHOLD;
        t_load = 1'b1;
        t_val  = TW'(RESET_CYC - 1);
      end
      S_RHOLD: if (t_zero) nxt = S_RCHK;
      S_RCHK: begin
        if (done_s) begin
          nxt    = S_IDLE;
          stat_n = STAT_RST_FAIL;
        end else begin
          nxt    = S_HKEEP;
          t_load = 1'b1;
          t_val  = TW'(HK_CYC - 1);
        end
      end
      S_HKEEP: if (t_zero) nxt = S_GAP;
      S_GAP:   nxt = S_LOAD;
      S_LOAD: begin
        ser_go = in_valid && in_ready;
        if (ser_fin && last_q) nxt = S_DCHK;
      end
      S_DCHK: begin
        if (!done_s) begin
          nxt    = S_IDLE;
          stat_n = STAT_LD_FAIL;
        end else begin
          nxt = S_PAD;
        end
      end
      S_PAD: begin
        ser_din = '0;
        if (ser_fin && pad_cnt == PW'(PAD_BYTES - 1)) begin
          nxt    = S_IDLE;
          stat_n = STAT_OK;
        end else begin
          ser_go = !ser_active;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      last_q  <= 1'b0;
      pad_cnt <= '0;
      stat_q  <= STAT_OK;
      rstn_q  <= 1'b1;
      csn_q   <= 1'b1;
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
      oper_q  <= 1'b0;
    end else begin
      state  <= nxt;
      oper_q <= done_s;
      if (state == S_IDLE) last_q <= 1'b0;
      else if (ser_go && state == S_LOAD && in_last) last_q <= 1'b1;
      if (state == S_DCHK) pad_cnt <= '0;
      else if (state == S_PAD && ser_fin) pad_cnt <= pad_cnt + 1'b1;
      fin_q <= (state != S_IDLE) && (nxt == S_IDLE);
      if ((state != S_IDLE) && (nxt == S_IDLE)) stat_q <= stat_n;
      rstn_q <= (nxt != S_RHOLD);
      csn_q  <= !(nxt == S_RHOLD || nxt == S_RCHK || nxt == S_HKEEP ||
                  nxt == S_LOAD  || nxt == S_DCHK || nxt == S_PAD);
      busy_q <= (nxt != S_IDLE);
    end
  end

  assign cfg_rst_n  = rstn_q;
  assign spi_cs_n   = csn_q;
  assign busy       = busy_q;
  assign fin_pulse  = fin_q;
  assign fin_status = stat_q;
  assign operating  = oper_q;
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       cfg_rst_n,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       busy,
  input logic       fin_pulse,
  input logic [1:0] fin_status
);
  AST_RST_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !cfg_rst_n |-> !spi_cs_n); // R1

  AST_CS_HELD_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_rst_n) |-> !spi_cs_n); // R2

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk); // R5

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R5

  AST_READY_SER_IDLE: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!spi_sclk && !spi_cs_n && busy)); // R6

  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fin_pulse |=> !fin_pulse); // R9

  AST_FIN_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    fin_pulse |-> !busy); // R9

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    fin_pulse |-> (fin_status != 2'd3)); // R9
endmodule

bind fpga_cfg_seq cfg_seq_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .cfg_rst_n(cfg_rst_n),
  .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .busy(busy), .fin_pulse(fin_pulse), .fin_status(fin_status)
);

// File: tb/sim_fpga_cfg_seq.sv
module sim_fpga_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int RCYC = 5;
  localparam int HCYC = 30;
  localparam int PADB = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, done_in = 1'b0;
  logic in_ready, cfg_rst_n, spi_cs_n, spi_sclk, spi_mosi;
  logic busy, fin_pulse, operating;
  logic [1:0] fin_status;

  fpga_cfg_seq #(.CLK_HZ(40_000_000), .SCLK_HALF(HALF), .RESET_CYC(RCYC),
                 .HK_CYC(HCYC), .PAD_BYTES(PADB)) u0 (
    .clk(clk), .rst(rst), .start(start), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .cfg_rst_n(cfg_rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .done_in(done_in), .busy(busy),
    .fin_pulse(fin_pulse), .fin_status(fin_status), .operating(operating)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int rst_lo, hk_cnt, cs_rise, cs_fall, nbits;
  logic [7:0] cap [0:31];
  logic [7:0] img [0:31];
  logic [7:0] shreg;
  logic pcs = 1'b1, psclk = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_bits(input int n, input int mode);
    if (mode == 1) return 0;
    if (mode == 2) return 8 * n;
    return 8 * n + 8 * PADB;
  endfunction

  function automatic int exp_hk(input int mode);
    return (mode == 1) ? 1 : HCYC + 1;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!cfg_rst_n) rst_lo++;
    if (cs_rise == 0 && !spi_cs_n && cfg_rst_n && busy) hk_cnt++;
    if (spi_cs_n && !pcs) cs_rise++;
    if (!spi_cs_n && pcs) cs_fall++;
    if (spi_sclk && !psclk && !spi_cs_n) begin
      shreg = {shreg[6:0], spi_mosi};
      if (nbits % 8 == 7 && nbits / 8 < 32) cap[nbits/8] = shreg;
      nbits++;
    end
    pcs = spi_cs_n;
    psclk = spi_sclk;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // mode: 0 success, 1 reset failure, 2 load failure; pat < 0 gives random bytes
  task automatic run(input int n, input int mode, input bit poke, input int pat);
    int gap;
    rst_lo = 0; hk_cnt = 0; cs_rise = 0; cs_fall = 0; nbits = 0;
    for (int i = 0; i < n; i++) img[i] = (pat < 0) ? 8'($urandom) : 8'(pat);
    done_in = (mode == 1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (poke) begin
      repeat (RCYC + 5) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    if (mode != 1) begin
      for (int i = 0; i < n; i++) begin
        gap = $urandom_range(0, 3);
        repeat (gap) @(negedge clk);
        in_data = img[i]; in_last = (i == n - 1); in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        if (i == n - 1 && mode == 0) done_in = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R6", "ready drops after take", in_ready, 0);
        in_valid = 1'b0; in_last = 1'b0;
      end
    end
    while (!fin_pulse) @(negedge clk);
    chk(fin_status == 2'(mode), (mode == 1) ? "R3" : (mode == 2) ? "R7" : "R8",
        "status", fin_status, mode);
    chk(busy == 1'b0, "R9", "busy at finish", busy, 0);
    chk(spi_cs_n == 1'b1, "R9", "select released at finish", spi_cs_n, 1);
    @(negedge clk);
    chk(fin_pulse == 1'b0, "R9", "finish pulse width", fin_pulse, 0);
    chk(rst_lo == RCYC, poke ? "R11" : "R1", "reset low cycles", rst_lo, RCYC);
    chk(hk_cnt == exp_hk(mode), "R2", "select low after release", hk_cnt, exp_hk(mode));
    chk(nbits == exp_bits(n, mode), (mode == 0) ? "R8" : (mode == 1) ? "R3" : "R7",
        "sclk rising edges", nbits, exp_bits(n, mode));
    chk(cs_fall == ((mode == 1) ? 1 : 2), poke ? "R11" : "R4", "select falls",
        cs_fall, (mode == 1) ? 1 : 2);
    chk(cs_rise == ((mode == 1) ? 1 : 2), "R4", "select rises",
        cs_rise, (mode == 1) ? 1 : 2);
    if (mode != 1)
      for (int i = 0; i < n; i++)
        chk(cap[i] == img[i], "R5", "shifted byte", cap[i], img[i]);
    if (mode == 0)
      for (int i = 0; i < PADB; i++)
        chk(cap[n+i] == 8'h00, "R8", "pad byte", cap[n+i], 0);
    repeat (4) @(negedge clk);
    chk(operating == done_in, "R10", "operating follows done", operating, done_in);
    if (mode != 0) begin
      done_in = 1'b1;
      repeat (4) @(negedge clk);
      chk(operating == 1'b1, "R10", "operating rises", operating, 1);
    end
    done_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(operating == 1'b0, "R10", "operating falls", operating, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_rst_n == 1'b1, "R1", "reset state cfg_rst_n", cfg_rst_n, 1);
    chk(spi_cs_n == 1'b1, "R4", "reset state cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R5", "reset state sclk", spi_sclk, 0);
    chk(busy == 1'b0, "R9", "reset state busy", busy, 0);
    chk(in_ready == 1'b0, "R6", "reset state ready", in_ready, 0);
    run(1, 0, 1'b0, 8'h80);   // MSB-first corner
    run(1, 0, 1'b0, 8'h01);
    run(2, 0, 1'b0, 8'hFF);
    run(3, 1, 1'b0, -1);      // reset failure
    run(4, 2, 1'b0, -1);      // load failure
    run(5, 0, 1'b1, -1);      // start while busy
    for (int k = 0; k < 4; k++) run($urandom_range(1, 6), 0, 1'b0, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule